// File: doc/BRIEF.md
# Cascadable Dual Event Counter

The block counts edges on two external event inputs. Both inputs are already synchronized to the system clock. Each input drives its own 16-bit counter, and a per-channel polarity bit selects whether that counter advances on rising or on falling edges. A cascade mode joins the two counters into one 32-bit counter. In that mode the first input is the only count source and the second counter holds the upper half.

Software reaches the block through a small register port. The port has a write strobe, an address, write data and combinational read data. Address 0 holds the control byte. Addresses 1 to 4 hold the count bytes.

Reads of the count bytes never see the live counters. They return a holding register, which a self-clearing snapshot command loads with all four bytes in one clock edge. Software therefore reads a coherent 32-bit value while counting goes on. Writes to the count bytes preload the live counters.

Top module: `evc_counter_pair`

## Requirements
- R1: After reset, both live counters, the snapshot register and the control byte are zero. Every address from 0 to 7 reads 0x00.
- R2: Control byte at address 0 has these fields:
  - bit 0: polarity of counter A.
  - bit 1: polarity of counter B.
  - bit 2: cascade enable.
  - bit 3: snapshot command.
  - bits 7..4: read as 0.
  - Bit 3 is never stored, so it always reads 0.
  - Addresses 5 to 7 read 0x00.
- R3: A polarity bit of 0 makes its counter advance by one on each falling edge of its input. A polarity bit of 1 makes it advance on each rising edge.
- R4: With cascade off, counter A counts only input A and counter B counts only input B.
- R5: With cascade on, input B and the counter-B polarity bit have no effect. Counter A counts input A. A count that takes counter A from 0xFFFF to 0x0000 increments counter B at the same clock edge.
- R6: Writing a control byte with bit 3 set copies both live counters into the snapshot register at that edge. Addresses 1 to 4 return the snapshot bytes, and the snapshot changes only on another such write. The byte order is:
  - address 1: counter A low byte.
  - address 2: counter A high byte.
  - address 3: counter B low byte.
  - address 4: counter B high byte.
- R7: An edge that arrives in the same cycle as a snapshot command is counted by the live counter. It is absent from that snapshot and appears in the next one.
- R8: A write to addresses 1 to 4 loads that byte of the live counter. The write overrides a count event on the same counter in the same cycle.
- R9: With cascade off, each counter wraps from 0xFFFF to 0x0000 without disturbing the other counter.
- R10: Changing a polarity bit from 0 to 1 while its input is held high produces exactly one count on that counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_a_i | input | 1 | Event input A, synchronous to clk |
| evt_b_i | input | 1 | Event input B, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |

## Verification
A wrong edge-detector state shows up as a missing or extra count. It becomes visible at the next snapshot read after the offending edge, or, for a polarity change, one clock after the control write. A broken carry or a wrong write priority corrupts the upper or written byte at the very next clock edge. The snapshot register is the only path to the read port. A capture taken one edge early or late therefore shows as an off-by-one count, and the same-cycle edge case is aimed at exactly that.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned CTRL_SNAP_BIT = 3;

  typedef struct packed {
    logic cascade;
    logic pol_b;
    logic pol_a;
  } ctrl_t;
endpackage

// File: rtl/evc_edge.sv
module evc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_mode_i,
  output logic hit_o
);
  logic norm;
  logic prev_q;

  // Normalise the input so that the selected edge is always a rising one.
  always_comb begin
    norm  = rise_mode_i ? lvl_i : ~lvl_i;
    hit_o = norm & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= norm;
  end
endmodule

// File: rtl/evc_count.sv
module evc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inc_i,
  input  logic [CNT_W/8-1:0]          ld_en_i,
  input  logic [evc_pkg::BYTE_W-1:0]  ld_byte_i,
  output logic [CNT_W-1:0]            cnt_o,
  output logic                        max_o
);
  localparam int unsigned NB = CNT_W / evc_pkg::BYTE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = inc_i | (|ld_en_i);
    if (|ld_en_i) begin
      for (int b = 0; b < NB; b++) begin
        if (ld_en_i[b]) cnt_d[b*evc_pkg::BYTE_W +: evc_pkg::BYTE_W] = ld_byte_i;
      end
    end else if (inc_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign max_o = &cnt_q;
endmodule

// File: rtl/evc_counter_pair.sv
module evc_counter_pair #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_a_i,
  input  logic              evt_b_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o
);
  import evc_pkg::*;

  localparam int unsigned NB     = CNT_W / BYTE_W;
  localparam int unsigned SNAP_W = 2 * CNT_W;

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_d;
  logic              ctrl_wr;
  logic              snap_take;
  logic              hit_a;
  logic              hit_b;
  logic              inc_a;
  logic              inc_b;
  logic              max_a;
  logic              max_b;
  logic [NB-1:0]     ld_a;
  logic [NB-1:0]     ld_b;
  logic [CNT_W-1:0]  cnt_a;
  logic [CNT_W-1:0]  cnt_b;
  logic [SNAP_W-1:0] snap_q;

  // Control register
  always_comb begin
    ctrl_wr   = reg_wr_i && (reg_addr_i == ADDR_W'(CTRL_ADDR));
    snap_take = ctrl_wr && reg_wdata_i[CTRL_SNAP_BIT];
    ctrl_d    = ctrl_t'(reg_wdata_i[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  // Edge detectors
  evc_edge u_edge_a (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_a_i),
    .rise_mode_i(ctrl_q.pol_a), .hit_o(hit_a)
  );
  evc_edge u_edge_b (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_b_i),
    .rise_mode_i(ctrl_q.pol_b), .hit_o(hit_b)
  );

  // Count sources and cascade carry
  always_comb begin
    inc_a = hit_a;
    inc_b = ctrl_q.cascade ? (hit_a & max_a) : hit_b;
  end

  // Byte load decode
  for (genvar b = 0; b < NB; b++) begin : g_ld
    assign ld_a[b] = reg_wr_i && (reg_addr_i == ADDR_W'(1 + b));
    assign ld_b[b] = reg_wr_i && (reg_addr_i == ADDR_W'(1 + NB + b));
  end

  evc_count #(.CNT_W(CNT_W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_a), .ld_en_i(ld_a),
    .ld_byte_i(reg_wdata_i), .cnt_o(cnt_a), .max_o(max_a)
  );
  evc_count #(.CNT_W(CNT_W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_b), .ld_en_i(ld_b),
    .ld_byte_i(reg_wdata_i), .cnt_o(cnt_b), .max_o(max_b)
  );

  // Snapshot holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_take) snap_q <= {cnt_b, cnt_a};
  end

  // Read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata_o = {5'b0, ctrl_q};
    end
    for (int i = 0; i < 2 * NB; i++) begin
      if (reg_addr_i == ADDR_W'(i + 1)) reg_rdata_o = snap_q[i*BYTE_W +: BYTE_W];
    end
  end

  // max_b has no consumer inside this block
  logic unused_ok;
  assign unused_ok = max_b;
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              cascade,
  input logic              hit_a,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  cnt_b,
  input logic [2*CNT_W-1:0] snap
);
  a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == '0 && wdata[3]) |=> $stable(snap));

  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rdata[7:3] == 5'b0));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + CNT_W'(1)));

  a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !wr && hit_a && (&cnt_a)) |=>
      (cnt_a == '0 && cnt_b == $past(cnt_b) + CNT_W'(1)));

  a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !wr && !(hit_a && (&cnt_a))) |=> $stable(cnt_b));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(1)) |=> (cnt_a[7:0] == $past(wdata)));
endmodule

bind evc_counter_pair evc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(reg_wr_i), .addr(reg_addr_i),
  .wdata(reg_wdata_i), .rdata(reg_rdata_o), .cascade(ctrl_q.cascade),
  .hit_a(hit_a), .cnt_a(cnt_a), .cnt_b(cnt_b), .snap(snap_q)
);

// File: tb/tb_evc_counter_pair.sv
module tb_evc_counter_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_a = 1'b0;
  logic       evt_b = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] ctrl_sh = '0;

  always #2 clk = ~clk;

  evc_counter_pair dut (
    .clk(clk), .rst_n(rst_n), .evt_a_i(evt_a), .evt_b_i(evt_b),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
    if (a == 3'd0) ctrl_sh = d & 8'h07;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic read_snap(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      reg_read(3'(i + 1), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic get32(output logic [31:0] v);
    reg_write(3'd0, ctrl_sh | 8'h08);
    read_snap(v);
  endtask

  task automatic set32(input logic [31:0] v);
    for (int i = 0; i < 4; i++) reg_write(3'(i + 1), v[i*8 +: 8]);
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_a = 1'b1;
      @(negedge clk); evt_a = 1'b0;
    end
  endtask

  task automatic pulse_b(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_b = 1'b1;
      @(negedge clk); evt_b = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [31:0] v;
    reg_read(3'd0, b); check("R1 ctrl", 32'(b), 32'h0);
    read_snap(v);      check("R1 snapshot", v, 32'h0);
    get32(v);          check("R1 live", v, 32'h0);
  endtask

  task automatic t_falling;
    logic [31:0] v;
    reg_write(3'd0, 8'h00); set32(32'h0);
    pulse_a(3); pulse_b(2);
    get32(v); check("R3 R4 falling edges", v, 32'h0002_0003);
  endtask

  task automatic t_rising;
    logic [31:0] v;
    reg_write(3'd0, 8'h03); set32(32'h0);
    pulse_a(4); pulse_b(1);
    get32(v); check("R3 R4 rising edges", v, 32'h0001_0004);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    reg_write(3'd0, 8'h03); set32(32'h1234_FFFE);
    pulse_a(2);
    get32(v); check("R9 wrap", v, 32'h1234_0000);
  endtask

  task automatic t_cascade;
    logic [31:0] v;
    reg_write(3'd0, 8'h05); set32(32'h00AB_FFFF);
    pulse_a(1);
    get32(v); check("R5 carry", v, 32'h00AC_0000);
    pulse_b(3);
    get32(v); check("R5 input B ignored", v, 32'h00AC_0000);
    reg_write(3'd0, 8'h07); pulse_b(2);
    get32(v); check("R5 B polarity ignored", v, 32'h00AC_0000);
    pulse_a(1);
    get32(v); check("R5 low count", v, 32'h00AC_0001);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    reg_write(3'd0, 8'h01); set32(32'h0000_1200);
    @(negedge clk); wr = 1'b1; addr = 3'd1; wdata = 8'h55; evt_a = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk); evt_a = 1'b0;
    get32(v); check("R8 write beats count", v, 32'h0000_1255);
  endtask

  task automatic t_snap;
    logic [31:0] v;
    reg_write(3'd0, 8'h01); set32(32'h0000_0010);
    @(negedge clk); wr = 1'b1; addr = 3'd0; wdata = 8'h09; evt_a = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk); evt_a = 1'b0;
    read_snap(v); check("R7 same-cycle edge excluded", v, 32'h0000_0010);
    pulse_a(2);
    read_snap(v); check("R6 snapshot held", v, 32'h0000_0010);
    get32(v);     check("R7 edge in next snapshot", v, 32'h0000_0013);
  endtask

  task automatic t_polchg;
    logic [31:0] v;
    reg_write(3'd0, 8'h00); set32(32'h0);
    @(negedge clk); evt_a = 1'b1;
    @(negedge clk);
    reg_write(3'd0, 8'h01);
    @(negedge clk); evt_a = 1'b0;
    @(negedge clk);
    get32(v); check("R10 polarity change count", v, 32'h0000_0001);
  endtask

  task automatic t_ctrl;
    logic [7:0] b;
    reg_write(3'd0, 8'hF2); reg_read(3'd0, b); check("R2 upper bits", 32'(b), 32'h02);
    reg_write(3'd0, 8'h0D); reg_read(3'd0, b); check("R2 snap bit reads 0", 32'(b), 32'h05);
    for (int a = 5; a < 8; a++) begin
      reg_read(3'(a), b); check("R2 unused address", 32'(b), 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_falling; t_rising; t_wrap; t_cascade;
    t_priority; t_snap; t_polchg; t_ctrl;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule